// File: doc/BRIEF.md
# Colour Lookup Table with Sequenced Component Access

This block is a register-mapped colour lookup table for a display path. It stores 256 normal colour entries and a separate bank of 4 overlay entries (entries 256 to 259), each holding an 8-bit red, green and blue component. Software reaches it through a 32-bit word-access register port. It first sets an 8-bit entry index. It then moves colour components through a single data register one at a time, always red first, then green, then blue. After the blue component the index advances to the next entry, so a whole palette can be loaded or dumped as one stream.

A second port serves the pixel pipeline. It takes a 9-bit entry number and returns the packed 24-bit colour of that entry in the same cycle.

The component sequencer is the core of the design. It has three named states: `PH_RED`, `PH_GRN` and `PH_BLU`. The transitions are:
- `PH_RED -> PH_GRN` and `PH_GRN -> PH_BLU` on any colour access (a write to either colour register, or a read).
- `PH_BLU -> PH_RED` on a colour access, together with an index increment.
- `any -> PH_RED` on an index-register write.

Every other cycle holds the state.

Top module: `clut_dac`

## Requirements
- R1: A write to byte offset 0 loads the entry index from bits 31:24 of the written word and returns the sequencer to `PH_RED`.
- R2: Successive writes to byte offset 4 store bits 31:24 of the written word into the red, then green, then blue component of normal entry `index`.
- R3: A colour access made in `PH_BLU` increments the index modulo 256 (255 wraps to 0) and returns the sequencer to `PH_RED`.
- R4: Writes to byte offset 12 follow the same red, green, blue sequence, but store into overlay entry 256 + (index & 3). After blue, the full 8-bit index still increments.
- R5: `rdata` shows, in bits 31:24, the current-phase component of normal entry `index`, with bits 23:0 zero. A read (`req` high, `we` low) at any offset advances the sequencer exactly as a colour write does. Reads and writes share one sequencer.
- R6: A write to any byte offset other than 0, 4 or 12 changes no entry, no index and no phase.
- R7: After reset, every entry is black (0x000000) except entries 255, 256 and 258, which are white (0xFFFFFF). The index is 0 and the phase is `PH_RED`.
- R8: `lk_rgb` carries entry `lk_idx` as {red[23:16], green[15:8], blue[7:0]} combinationally. For `lk_idx` of 260 or above it is 0.
- R9: A component written at a clock edge is visible on `lk_rgb` in the cycle following that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Register access in this cycle |
| we | input | 1 | 1 = write, 0 = read |
| ofs | input | 4 | Byte offset of the access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data: current component in bits 31:24 |
| lk_idx | input | 9 | Lookup entry number |
| lk_rgb | output | 24 | Lookup colour {R,G,B} |

## Verification
The sequencer is driven with several access patterns:
- Plain three-write entry loads at a mid index.
- A load at index 255 followed by a second triple, which separates a modulo wrap from a 9-bit carry into the overlay bank.
- Overlay loads whose index low bits select different overlay slots while the index itself keeps counting.
- Reads that stop mid-entry and are then restarted by an index write, which shows that the index write resets the phase.
- Reads interleaved with writes, which shows that reads and writes share one phase.
- Writes to the unused offsets, which must leave both the stream position and the table untouched.

Lookups just before and just after the blue write pin down when an update becomes visible. Lookups beyond entry 259 check the zero fill.

// File: rtl/clut_pkg.sv
package clut_pkg;

    // Component sequencer state
    typedef enum logic [1:0] {
        PH_RED = 2'd0,
        PH_GRN = 2'd1,
        PH_BLU = 2'd2
    } phase_e;

    // Decoded access kind
    typedef enum logic [2:0] {
        OP_IDLE   = 3'd0,
        OP_SETIDX = 3'd1,
        OP_WR_NRM = 3'd2,
        OP_WR_OVL = 3'd3,
        OP_READ   = 3'd4
    } op_e;

    // Byte offsets the register port decodes
    localparam int OFS_INDEX = 0;
    localparam int OFS_NORM  = 4;
    localparam int OFS_OVL   = 12;

endpackage

// File: rtl/clut_decode.sv
module clut_decode
    import clut_pkg::*;
#(
    parameter int OFS_W = 4
) (
    input  logic             req,
    input  logic             we,
    input  logic [OFS_W-1:0] ofs,
    output op_e              op
);

    always_comb begin
        op = OP_IDLE;
        if (req && !we) begin
            op = OP_READ;
        end else if (req && we) begin
            if (ofs == OFS_W'(OFS_INDEX)) begin
                op = OP_SETIDX;
            end else if (ofs == OFS_W'(OFS_NORM)) begin
                op = OP_WR_NRM;
            end else if (ofs == OFS_W'(OFS_OVL)) begin
                op = OP_WR_OVL;
            end
        end
    end

endmodule

// File: rtl/clut_seq.sv
module clut_seq
    import clut_pkg::*;
#(
    parameter int NORM_N = 256,
    parameter int OVL_N  = 4,
    parameter int IDX_W  = $clog2(NORM_N),
    parameter int SEL_W  = $clog2(NORM_N + OVL_N)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  op_e              op,
    input  logic [IDX_W-1:0] idx_load,
    output logic [IDX_W-1:0] idx_q,
    output phase_e           phase_q,
    output logic             wr_en,
    output logic [SEL_W-1:0] wr_sel,
    output logic [SEL_W-1:0] rd_sel
);

    localparam int OVL_W = (OVL_N > 1) ? $clog2(OVL_N) : 1;

    phase_e           phase_d;
    logic [IDX_W-1:0] idx_d;
    logic             step;

    assign step = (op == OP_WR_NRM) || (op == OP_WR_OVL) || (op == OP_READ);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= PH_RED;
            idx_q   <= '0;
        end else begin
            phase_q <= phase_d;
            idx_q   <= idx_d;
        end
    end

    // Next state
    always_comb begin
        phase_d = phase_q;
        idx_d   = idx_q;
        if (op == OP_SETIDX) begin
            phase_d = PH_RED;
            idx_d   = idx_load;
        end else if (step) begin
            unique case (phase_q)
                PH_RED:  phase_d = PH_GRN;
                PH_GRN:  phase_d = PH_BLU;
                PH_BLU: begin
                    phase_d = PH_RED;
                    idx_d   = idx_q + IDX_W'(1);
                end
                default: phase_d = PH_RED;
            endcase
        end
    end

    // Outputs
    always_comb begin
        wr_en  = (op == OP_WR_NRM) || (op == OP_WR_OVL);
        rd_sel = SEL_W'(idx_q);
        if (op == OP_WR_OVL) begin
            wr_sel = SEL_W'(NORM_N) + SEL_W'(idx_q[OVL_W-1:0]);
        end else begin
            wr_sel = SEL_W'(idx_q);
        end
    end

endmodule

// File: rtl/clut_store.sv
module clut_store
    import clut_pkg::*;
#(
    parameter int NORM_N = 256,
    parameter int OVL_N  = 4,
    parameter int COMP_W = 8,
    parameter int SEL_W  = $clog2(NORM_N + OVL_N)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [SEL_W-1:0]    wr_sel,
    input  phase_e              wr_ph,
    input  logic [COMP_W-1:0]   wr_val,
    input  logic [SEL_W-1:0]    rd_sel,
    input  phase_e              rd_ph,
    output logic [COMP_W-1:0]   rd_val,
    input  logic [SEL_W-1:0]    lk_sel,
    output logic [3*COMP_W-1:0] lk_rgb
);

    localparam int ENT_N = NORM_N + OVL_N;
    localparam int RGB_W = 3 * COMP_W;

    logic [RGB_W-1:0] ent_w [ENT_N];

    for (genvar e = 0; e < ENT_N; e++) begin : g_ent
        localparam bit WHITE = (e == NORM_N - 1) || (e == NORM_N) || (e == NORM_N + 2);
        localparam logic [RGB_W-1:0] RST_VAL = WHITE ? {RGB_W{1'b1}} : {RGB_W{1'b0}};
        logic [RGB_W-1:0] ent_q;
        logic             hit;

        assign hit = wr_en && (wr_sel == SEL_W'(e));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ent_q <= RST_VAL;
            end else if (hit) begin
                unique case (wr_ph)
                    PH_RED:  ent_q[3*COMP_W-1 -: COMP_W] <= wr_val;
                    PH_GRN:  ent_q[2*COMP_W-1 -: COMP_W] <= wr_val;
                    PH_BLU:  ent_q[COMP_W-1 -: COMP_W]   <= wr_val;
                    default: ent_q <= ent_q;
                endcase
            end
        end

        assign ent_w[e] = ent_q;
    end

    // Pixel-side lookup, zero beyond the last entry
    always_comb begin
        if (lk_sel < SEL_W'(ENT_N)) begin
            lk_rgb = ent_w[lk_sel];
        end else begin
            lk_rgb = '0;
        end
    end

    // Register-side component read
    logic [RGB_W-1:0] rd_ent;
    always_comb begin
        rd_ent = (rd_sel < SEL_W'(ENT_N)) ? ent_w[rd_sel] : '0;
        unique case (rd_ph)
            PH_RED:  rd_val = rd_ent[3*COMP_W-1 -: COMP_W];
            PH_GRN:  rd_val = rd_ent[2*COMP_W-1 -: COMP_W];
            PH_BLU:  rd_val = rd_ent[COMP_W-1 -: COMP_W];
            default: rd_val = '0;
        endcase
    end

endmodule

// File: rtl/clut_dac.sv
module clut_dac
    import clut_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int COMP_W = 8,
    parameter int NORM_N = 256,
    parameter int OVL_N  = 4,
    parameter int OFS_W  = 4,
    parameter int SEL_W  = $clog2(NORM_N + OVL_N)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req,
    input  logic                we,
    input  logic [OFS_W-1:0]    ofs,
    input  logic [DATA_W-1:0]   wdata,
    output logic [DATA_W-1:0]   rdata,
    input  logic [SEL_W-1:0]    lk_idx,
    output logic [3*COMP_W-1:0] lk_rgb
);

    localparam int IDX_W = $clog2(NORM_N);

    op_e              op;
    logic [IDX_W-1:0] idx_q;
    phase_e           phase_q;
    logic             wr_en;
    logic [SEL_W-1:0] wr_sel;
    logic [SEL_W-1:0] rd_sel;
    logic [COMP_W-1:0] rd_val;

    clut_decode #(.OFS_W(OFS_W)) u_dec (
        .req (req),
        .we  (we),
        .ofs (ofs),
        .op  (op)
    );

    clut_seq #(
        .NORM_N(NORM_N), .OVL_N(OVL_N), .IDX_W(IDX_W), .SEL_W(SEL_W)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .op       (op),
        .idx_load (wdata[DATA_W-1 -: IDX_W]),
        .idx_q    (idx_q),
        .phase_q  (phase_q),
        .wr_en    (wr_en),
        .wr_sel   (wr_sel),
        .rd_sel   (rd_sel)
    );

    clut_store #(
        .NORM_N(NORM_N), .OVL_N(OVL_N), .COMP_W(COMP_W), .SEL_W(SEL_W)
    ) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_sel (wr_sel),
        .wr_ph  (phase_q),
        .wr_val (wdata[DATA_W-1 -: COMP_W]),
        .rd_sel (rd_sel),
        .rd_ph  (phase_q),
        .rd_val (rd_val),
        .lk_sel (lk_idx),
        .lk_rgb (lk_rgb)
    );

    assign rdata = {rd_val, {(DATA_W-COMP_W){1'b0}}};

endmodule

// File: rtl/clut_dac_chk.sv
module clut_dac_chk #(
    parameter int DATA_W = 32,
    parameter int COMP_W = 8,
    parameter int NORM_N = 256,
    parameter int OVL_N  = 4,
    parameter int OFS_W  = 4,
    parameter int SEL_W  = 9,
    parameter int IDX_W  = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                req,
    input logic                we,
    input logic [OFS_W-1:0]    ofs,
    input logic [DATA_W-1:0]   wdata,
    input logic [SEL_W-1:0]    lk_idx,
    input logic [3*COMP_W-1:0] lk_rgb,
    input logic [IDX_W-1:0]    cur_idx,
    input logic [1:0]          cur_ph
);

    logic set_idx, col_acc, dead_wr, nrm_wr;
    assign set_idx = req && we && (ofs == OFS_W'(0));
    assign nrm_wr  = req && we && (ofs == OFS_W'(4));
    assign col_acc = req && (!we || ofs == OFS_W'(4) || ofs == OFS_W'(12));
    assign dead_wr = req && we && !(ofs == OFS_W'(0) || ofs == OFS_W'(4) || ofs == OFS_W'(12));

    AST_INDEX_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        set_idx |=> (cur_idx == $past(wdata[DATA_W-1 -: IDX_W])) && (cur_ph == 2'd0)); // R1

    AST_RED_TO_GRN: assert property (@(posedge clk) disable iff (!rst_n)
        (col_acc && cur_ph == 2'd0) |=> (cur_ph == 2'd1)); // R2

    AST_GRN_TO_BLU: assert property (@(posedge clk) disable iff (!rst_n)
        (col_acc && cur_ph == 2'd1) |=> (cur_ph == 2'd2)); // R2

    AST_PHASE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        cur_ph != 2'd3); // R2

    AST_BLUE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (col_acc && cur_ph == 2'd2) |=> (cur_ph == 2'd0) && (cur_idx == IDX_W'($past(cur_idx) + 1'b1))); // R3

    AST_DEAD_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        dead_wr |=> $stable(cur_idx) && $stable(cur_ph)); // R6

    AST_LOOKUP_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_idx >= SEL_W'(NORM_N + OVL_N)) |-> (lk_rgb == '0)); // R8

    AST_FRESH_RED: assert property (@(posedge clk) disable iff (!rst_n)
        (nrm_wr && cur_ph == 2'd0 && lk_idx == SEL_W'(cur_idx)) |=>
        (!$stable(lk_idx) || lk_rgb[3*COMP_W-1 -: COMP_W] == $past(wdata[DATA_W-1 -: COMP_W]))); // R9

endmodule

bind clut_dac clut_dac_chk #(
    .DATA_W(DATA_W), .COMP_W(COMP_W), .NORM_N(NORM_N), .OVL_N(OVL_N),
    .OFS_W(OFS_W), .SEL_W(SEL_W), .IDX_W(IDX_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .req     (req),
    .we      (we),
    .ofs     (ofs),
    .wdata   (wdata),
    .lk_idx  (lk_idx),
    .lk_rgb  (lk_rgb),
    .cur_idx (idx_q),
    .cur_ph  (phase_q)
);

// File: tb/clut_dac_bench.sv
module clut_dac_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic        we = 1'b0;
    logic [3:0]  ofs = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [8:0]  lk_idx = '0;
    logic [23:0] lk_rgb;

    int n_chk = 0;
    int n_err = 0;
    bit done = 0;

    // reference model built from the requirements
    logic [7:0] mr [260];
    logic [7:0] mg [260];
    logic [7:0] mb [260];
    logic [7:0] midx;
    int         mph;

    always #10 clk = ~clk;

    clut_dac u_clut_dac (
        .clk(clk), .rst_n(rst_n), .req(req), .we(we), .ofs(ofs),
        .wdata(wdata), .rdata(rdata), .lk_idx(lk_idx), .lk_rgb(lk_rgb)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < 260; i++) begin
            mr[i] = 8'h00; mg[i] = 8'h00; mb[i] = 8'h00;
        end
        mr[255] = 8'hFF; mg[255] = 8'hFF; mb[255] = 8'hFF;
        mr[256] = 8'hFF; mg[256] = 8'hFF; mb[256] = 8'hFF;
        mr[258] = 8'hFF; mg[258] = 8'hFF; mb[258] = 8'hFF;
        midx = 8'd0;
        mph  = 0;
    endtask

    task automatic model_step();
        if (mph == 2) begin
            mph = 0;
            midx = midx + 8'd1;
        end else begin
            mph++;
        end
    endtask

    task automatic bus_wr(input logic [3:0] o, input logic [31:0] d);
        int t;
        @(negedge clk);
        req = 1'b1; we = 1'b1; ofs = o; wdata = d;
        @(negedge clk);
        req = 1'b0; we = 1'b0;
        if (o == 4'd0) begin
            midx = d[31:24];
            mph  = 0;
        end else if (o == 4'd4 || o == 4'd12) begin
            t = (o == 4'd4) ? int'(midx) : 256 + int'(midx[1:0]);
            if (mph == 0) mr[t] = d[31:24];
            else if (mph == 1) mg[t] = d[31:24];
            else mb[t] = d[31:24];
            model_step();
        end
    endtask

    task automatic bus_rd(input string tag);
        logic [7:0] e;
        @(negedge clk);
        req = 1'b1; we = 1'b0;
        #1;
        e = (mph == 0) ? mr[midx] : (mph == 1) ? mg[midx] : mb[midx];
        check(tag, rdata, {e, 24'h0});
        @(negedge clk);
        req = 1'b0;
        model_step();
    endtask

    task automatic look(input string tag, input int i);
        logic [23:0] e;
        lk_idx = 9'(i);
        #1;
        e = (i < 260) ? {mr[i], mg[i], mb[i]} : 24'h0;
        check(tag, {8'h0, lk_rgb}, {8'h0, e});
    endtask

    task automatic t_reset();
        look("R7 entry 0", 0);
        look("R7 entry 254", 254);
        look("R7 entry 255 white", 255);
        look("R7 entry 256 white", 256);
        look("R7 entry 257 black", 257);
        look("R7 entry 258 white", 258);
        look("R7 entry 259 black", 259);
        check("R7 rdata at reset", rdata, 32'h0);
    endtask

    task automatic t_colour();
        bus_wr(4'd0, 32'h05AB_CDEF);
        bus_wr(4'd4, 32'h11FF_FFFF);
        bus_wr(4'd4, 32'h2200_0000);
        look("R9 blue not yet written", 5);
        bus_wr(4'd4, 32'h3312_3456);
        look("R2 R9 entry 5 after blue", 5);
        check("R2 exact value", {8'h0, lk_rgb}, 32'h0011_2233);
        look("R3 neighbour 6 untouched", 6);
    endtask

    task automatic t_wrap();
        bus_wr(4'd0, 32'hFF00_0000);
        bus_wr(4'd4, 32'hA100_0000);
        bus_wr(4'd4, 32'hA200_0000);
        bus_wr(4'd4, 32'hA300_0000);
        bus_wr(4'd4, 32'hB100_0000);
        bus_wr(4'd4, 32'hB200_0000);
        bus_wr(4'd4, 32'hB300_0000);
        look("R3 entry 255 loaded", 255);
        look("R3 wrap to entry 0", 0);
        check("R3 wrap exact", {8'h0, lk_rgb}, 32'h00B1_B2B3);
        look("R3 no carry into overlay", 256);
    endtask

    task automatic t_overlay();
        bus_wr(4'd0, 32'h0600_0000);
        bus_wr(4'd12, 32'h1000_0000);
        bus_wr(4'd12, 32'h2000_0000);
        bus_wr(4'd12, 32'h3000_0000);
        look("R4 overlay 258", 258);
        look("R4 normal 6 untouched", 6);
        bus_wr(4'd12, 32'h4400_0000);
        bus_wr(4'd12, 32'h5500_0000);
        bus_wr(4'd12, 32'h6600_0000);
        look("R4 overlay 259 after increment", 259);
        check("R4 overlay exact", {8'h0, lk_rgb}, 32'h0044_5566);
        bus_rd("R4 index advanced to 8 read");
    endtask

    task automatic t_read();
        bus_wr(4'd0, 32'h0500_0000);
        bus_rd("R5 read red");
        bus_rd("R5 read green");
        bus_rd("R5 read blue");
        bus_rd("R5 read next entry red");
        bus_wr(4'd0, 32'hFF00_0000);
        bus_rd("R1 phase reset to red");
        bus_wr(4'd4, 32'h7700_0000);
        bus_rd("R5 shared phase read blue");
        bus_rd("R5 R3 wrapped read entry 0");
    endtask

    task automatic t_ignore();
        bus_wr(4'd0, 32'h0500_0000);
        bus_wr(4'd4, 32'hC000_0000);
        bus_wr(4'd8, 32'hEE00_0000);
        bus_wr(4'd2, 32'hEE00_0000);
        bus_wr(4'd15, 32'hEE00_0000);
        bus_rd("R6 phase held after dead writes");
        look("R6 entry 5 unchanged", 5);
        look("R6 entry 0 unchanged", 0);
        look("R6 overlay 257 unchanged", 257);
    endtask

    task automatic t_range();
        look("R8 entry 260 zero", 260);
        look("R8 entry 511 zero", 511);
        look("R8 entry 258 in range", 258);
    endtask

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_colour();
        t_wrap();
        t_overlay();
        t_read();
        t_ignore();
        t_range();
        repeat (2) @(negedge clk);
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        #2000000;
        if (!done) begin
            done = 1;
            n_chk++;
            n_err++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule